// File: doc/BRIEF.md
# Hot-Plug Slot Control and Status Logic

This block holds the slot control word and the slot status word of a hot-plug capable downstream port. Software reaches it through a configuration-write interface. A write that lands on the control word is treated as one command: it updates the enables and the indicators, can pulse the electromechanical lock, and always completes at once by raising a command-completed event. A write that lands on the status word clears event bits wherever it carries a 1. On the hardware side, slot-insertion and slot-removal requests update the presence state, and attention-button presses raise their own event. A hot-plug request is refused with a busy pulse while the lock is engaged.

The block combines the events with their enables and with the hot-plug interrupt enable to form a notification condition. Whenever that condition changes, it issues a one-cycle message request that carries the interrupt vector. The request is marked as MSI-X when MSI-X is enabled, and it is issued as a plain MSI when only MSI is enabled. When neither message mode is enabled, the legacy INTx output follows the condition as a level.

Top module: `hps_slot_ctrl`

## Requirements
- R1: The notification condition is true only when control bit 3 (hot-plug interrupt enable) is 1 and, for at least one i in 0..2, status event bit i and control enable bit i are both 1. The events are bit 0 attention button pressed, bit 1 presence changed and bit 2 command completed.
- R2: When MSI-X or MSI is enabled, each change of the condition, rising or falling, produces exactly one `msg_req` pulse one cycle wide, two clock edges after the write or event that caused it. `msg_vec` carries `irq_vec`, and `msg_msix` is 1 when MSI-X is enabled and 0 when only MSI is enabled.
- R3: Raising an event that is already set changes nothing and produces no message.
- R4: When neither message mode is enabled, `intx` follows the condition two edges after the cause, and `msg_req` stays 0. When a message mode is enabled, `intx` stays 0. A condition change caused by a write that hits the status word produces no message.
- R5: Every write that hits the control word sets status bit 2 (command completed) at the edge that applies the write. If the same write also clears that bit through the status word, the bit stays set.
- R6: A control write with data bit 8 set toggles status bit 4 (lock engaged). Control bit 8 always reads 0.
- R7: A status write clears event bit i only where data bit i is 1. The other event bits are left unchanged.
- R8: An accepted hot-plug request copies `hp_insert` into status bit 3 (presence state) and sets the presence-changed event. An `atn_press` sets the attention event.
- R9: A hot-plug request made while the lock is engaged is refused: `hp_busy` pulses one edge later, and the status word does not change.
- R10: After reset, the control word reads 0x00F0, which leaves the enables cleared and both indicator fields (bits 5:4 attention, bits 7:6 power) at the off code 2'b11. The status word reads 0, and `intx` and `msg_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_hit_ctl | input | 1 | The write overlaps the control word |
| cfg_hit_sts | input | 1 | The write overlaps the status word |
| cfg_wdata_ctl | input | 9 | Control write data (bit 8 is the lock command) |
| cfg_wdata_sts | input | 3 | Status write data, write 1 to clear an event |
| hp_req | input | 1 | Hot-plug request pulse |
| hp_insert | input | 1 | 1 for insertion, 0 for removal |
| hp_busy | output | 1 | Request refused because the lock is engaged |
| atn_press | input | 1 | Attention button press pulse |
| msix_en | input | 1 | MSI-X mode enabled |
| msi_en | input | 1 | MSI mode enabled |
| irq_vec | input | VEC_W | Interrupt vector number |
| slot_ctl | output | 16 | Control word readback |
| slot_sts | output | 16 | Status word readback |
| msg_req | output | 1 | Message interrupt request pulse |
| msg_msix | output | 1 | The request is an MSI-X message |
| msg_vec | output | VEC_W | Vector carried by the request |
| intx | output | 1 | INTx level |

## Verification
Several rules are checked by the assertions on every cycle. A message request only ever appears while a message mode is enabled, INTx only while no message mode is enabled, and INTx only while the interrupt enable is set. Every control write sets the command-completed bit, a lock command flips the lock state, and a busy indication only ever follows an engaged lock. The following behaviours can only be shown by the bench's scenarios:
- exactly one pulse per change of the condition, and no pulse when an event that is already set is raised again
- the correct vector and message kind
- the silent acknowledge through a status write
- selective clearing of event bits
- the reset values after activity

// File: rtl/hps_pkg.sv
package hps_pkg;
   // control word bit positions
   localparam int CB_AB_EN    = 0;
   localparam int CB_PD_EN    = 1;
   localparam int CB_CC_EN    = 2;
   localparam int CB_HP_IE    = 3;
   localparam int CB_ATN_LO   = 4;
   localparam int CB_PWR_LO   = 6;
   localparam int CB_LOCK_CMD = 8;
   localparam int CTL_W       = 9;
   // status word bit positions (events share index with their enables)
   localparam int EV_AB       = 0;
   localparam int EV_PD       = 1;
   localparam int EV_CC       = 2;
   localparam int EV_N        = 3;
   localparam int SB_PD_STATE = 3;
   localparam int SB_LOCK     = 4;
   localparam int WORD_W      = 16;

   typedef logic [EV_N-1:0] hps_ev_t;
endpackage

// File: rtl/hps_ctrl_reg.sv
module hps_ctrl_reg
   import hps_pkg::*;
#(
   parameter bit         HAS_ATN = 1'b1,
   parameter bit         HAS_LOCK = 1'b1,
   parameter logic [1:0] IND_OFF = 2'b11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctl,
   input  logic [CTL_W-1:0] wdata,
   output hps_ev_t          ev_en,
   output logic             hp_ie,
   output logic [1:0]       atn_ind,
   output logic [1:0]       pwr_ind,
   output logic             lock_pulse,
   output logic             cmd_done
);
   logic ab_en_d;
   logic ab_en_q, pd_en_q, cc_en_q, hp_ie_q;
   logic [1:0] atn_q, pwr_q;

   generate
      if (HAS_ATN) begin : g_ab_wr
         assign ab_en_d = wdata[CB_AB_EN];
      end else begin : g_ab_tie
         assign ab_en_d = 1'b0;
      end
      if (HAS_LOCK) begin : g_lock_cmd
         assign lock_pulse = wr_ctl & wdata[CB_LOCK_CMD];
      end else begin : g_lock_none
         assign lock_pulse = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ab_en_q <= 1'b0;
         pd_en_q <= 1'b0;
         cc_en_q <= 1'b0;
         hp_ie_q <= 1'b0;
         atn_q   <= IND_OFF;
         pwr_q   <= IND_OFF;
      end else if (wr_ctl) begin
         ab_en_q <= ab_en_d;
         pd_en_q <= wdata[CB_PD_EN];
         cc_en_q <= wdata[CB_CC_EN];
         hp_ie_q <= wdata[CB_HP_IE];
         atn_q   <= wdata[CB_ATN_LO +: 2];
         pwr_q   <= wdata[CB_PWR_LO +: 2];
      end
   end

   always_comb begin
      ev_en        = '0;
      ev_en[EV_AB] = ab_en_q;
      ev_en[EV_PD] = pd_en_q;
      ev_en[EV_CC] = cc_en_q;
   end
   assign hp_ie    = hp_ie_q;
   assign atn_ind  = atn_q;
   assign pwr_ind  = pwr_q;
   assign cmd_done = wr_ctl;
endmodule

// File: rtl/hps_status_reg.sv
module hps_status_reg
   import hps_pkg::*;
#(
   parameter bit HAS_ATN  = 1'b1,
   parameter bit HAS_LOCK = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    wr_sts,
   input  hps_ev_t w1c,
   input  logic    set_cc,
   input  logic    lock_toggle,
   input  logic    hp_req,
   input  logic    hp_insert,
   input  logic    atn_press,
   output hps_ev_t ev,
   output logic    pd_state,
   output logic    lock_sts,
   output logic    hp_busy
);
   hps_ev_t ev_set, ev_q;
   logic    lock_q, pd_q, busy_q, hp_ok;

   assign hp_ok = hp_req & ~lock_q;

   always_comb begin
      ev_set        = '0;
      ev_set[EV_PD] = hp_ok;
      ev_set[EV_CC] = set_cc;
      ev_set[EV_AB] = HAS_ATN ? atn_press : 1'b0;
   end

   // one flop per event: a set in the same cycle wins over a clear
   for (genvar i = 0; i < EV_N; i++) begin : g_ev
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ev_q[i] <= 1'b0;
         else if (ev_set[i])
            ev_q[i] <= 1'b1;
         else if (wr_sts && w1c[i])
            ev_q[i] <= 1'b0;
      end
   end

   generate
      if (HAS_LOCK) begin : g_lock
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          lock_q <= 1'b0;
            else if (lock_toggle) lock_q <= ~lock_q;
         end
      end else begin : g_nolock
         assign lock_q = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_q   <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         busy_q <= hp_req & lock_q;
         if (hp_ok) pd_q <= hp_insert;
      end
   end

   assign ev       = ev_q;
   assign pd_state = pd_q;
   assign lock_sts = lock_q;
   assign hp_busy  = busy_q;
endmodule

// File: rtl/hps_notify.sv
module hps_notify
   import hps_pkg::*;
#(
   parameter int VEC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  hps_ev_t          ev,
   input  hps_ev_t          ev_en,
   input  logic             hp_ie,
   input  logic             sts_wr,
   input  logic             msix_en,
   input  logic             msi_en,
   input  logic [VEC_W-1:0] vec,
   output logic             msg_req,
   output logic             msg_msix,
   output logic [VEC_W-1:0] msg_vec,
   output logic             intx
);
   logic cond, cond_q, sts_wr_q, msg_mode;

   assign cond     = hp_ie & (|(ev & ev_en));
   assign msg_mode = msix_en | msi_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_q   <= 1'b0;
         sts_wr_q <= 1'b0;
         msg_req  <= 1'b0;
         msg_msix <= 1'b0;
         msg_vec  <= '0;
         intx     <= 1'b0;
      end else begin
         cond_q   <= cond;
         sts_wr_q <= sts_wr;
         msg_req  <= (cond != cond_q) & msg_mode & ~sts_wr_q;
         intx     <= cond & ~msg_mode;
         if ((cond != cond_q) && msg_mode && !sts_wr_q) begin
            msg_msix <= msix_en;
            msg_vec  <= vec;
         end
      end
   end
endmodule

// File: rtl/hps_slot_ctrl.sv
module hps_slot_ctrl
   import hps_pkg::*;
#(
   parameter int         VEC_W    = 5,
   parameter bit         HAS_ATN  = 1'b1,
   parameter bit         HAS_LOCK = 1'b1,
   parameter logic [1:0] IND_OFF  = 2'b11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr,
   input  logic               cfg_hit_ctl,
   input  logic               cfg_hit_sts,
   input  logic [CTL_W-1:0]   cfg_wdata_ctl,
   input  logic [EV_N-1:0]    cfg_wdata_sts,
   input  logic               hp_req,
   input  logic               hp_insert,
   output logic               hp_busy,
   input  logic               atn_press,
   input  logic               msix_en,
   input  logic               msi_en,
   input  logic [VEC_W-1:0]   irq_vec,
   output logic [WORD_W-1:0]  slot_ctl,
   output logic [WORD_W-1:0]  slot_sts,
   output logic               msg_req,
   output logic               msg_msix,
   output logic [VEC_W-1:0]   msg_vec,
   output logic               intx
);
   localparam int PAD_CTL = WORD_W - CTL_W;
   localparam int PAD_STS = WORD_W - SB_LOCK - 1;

   generate
      if (VEC_W < 1 || VEC_W > 5) begin : g_bad_vec
         $error("hps_slot_ctrl: VEC_W must lie in 1..5");
      end
   endgenerate

   logic    wr_ctl, wr_sts, hp_ie, lock_pulse, cmd_done, pd_state, lock_sts;
   logic [1:0] atn_ind, pwr_ind;
   hps_ev_t ev_en, ev;

   assign wr_ctl = cfg_wr & cfg_hit_ctl;
   assign wr_sts = cfg_wr & cfg_hit_sts;

   hps_ctrl_reg #(.HAS_ATN(HAS_ATN), .HAS_LOCK(HAS_LOCK), .IND_OFF(IND_OFF)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wdata(cfg_wdata_ctl),
      .ev_en(ev_en), .hp_ie(hp_ie), .atn_ind(atn_ind), .pwr_ind(pwr_ind),
      .lock_pulse(lock_pulse), .cmd_done(cmd_done)
   );

   hps_status_reg #(.HAS_ATN(HAS_ATN), .HAS_LOCK(HAS_LOCK)) u_sts (
      .clk(clk), .rst_n(rst_n), .wr_sts(wr_sts), .w1c(cfg_wdata_sts),
      .set_cc(cmd_done), .lock_toggle(lock_pulse), .hp_req(hp_req),
      .hp_insert(hp_insert), .atn_press(atn_press), .ev(ev),
      .pd_state(pd_state), .lock_sts(lock_sts), .hp_busy(hp_busy)
   );

   hps_notify #(.VEC_W(VEC_W)) u_ntf (
      .clk(clk), .rst_n(rst_n), .ev(ev), .ev_en(ev_en), .hp_ie(hp_ie),
      .sts_wr(wr_sts), .msix_en(msix_en), .msi_en(msi_en), .vec(irq_vec),
      .msg_req(msg_req), .msg_msix(msg_msix), .msg_vec(msg_vec), .intx(intx)
   );

   // lock command bit is never stored: it reads back as 0
   assign slot_ctl = {{PAD_CTL{1'b0}}, 1'b0, pwr_ind, atn_ind, hp_ie, ev_en};
   assign slot_sts = {{PAD_STS{1'b0}}, lock_sts, pd_state, ev};
endmodule

// File: rtl/hps_slot_ctrl_chk.sv
module hps_slot_ctrl_chk #(
   parameter int VEC_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr,
   input logic             cfg_hit_ctl,
   input logic [8:0]       cfg_wdata_ctl,
   input logic             hp_busy,
   input logic             msix_en,
   input logic             msi_en,
   input logic [15:0]      slot_ctl,
   input logic [15:0]      slot_sts,
   input logic             msg_req,
   input logic             msg_msix,
   input logic             intx
);
   a_r2_msg_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
      msg_req |-> $past(msix_en || msi_en));
   a_r2_msix_kind: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_req && msg_msix) |-> $past(msix_en));
   a_r4_intx_no_msg_mode: assert property (@(posedge clk) disable iff (!rst_n)
      intx |-> $past(!msix_en && !msi_en));
   a_r1_intx_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
      intx |-> $past(slot_ctl[3]));
   a_r5_cmd_completes: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_hit_ctl) |=> slot_sts[2]);
   a_r6_lock_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_hit_ctl && cfg_wdata_ctl[8]) |=> (slot_sts[4] != $past(slot_sts[4])));
   a_r9_busy_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
      hp_busy |-> $past(slot_sts[4]));
endmodule

bind hps_slot_ctrl hps_slot_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_hit_ctl(cfg_hit_ctl),
   .cfg_wdata_ctl(cfg_wdata_ctl), .hp_busy(hp_busy), .msix_en(msix_en),
   .msi_en(msi_en), .slot_ctl(slot_ctl), .slot_sts(slot_sts),
   .msg_req(msg_req), .msg_msix(msg_msix), .intx(intx)
);

// File: tb/hps_slot_ctrl_bench.sv
`timescale 1ns/1ps
module hps_slot_ctrl_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 0, cfg_hit_ctl = 0, cfg_hit_sts = 0;
   logic [8:0] cfg_wdata_ctl = '0;
   logic [2:0] cfg_wdata_sts = '0;
   logic hp_req = 0, hp_insert = 0, atn_press = 0, msix_en = 0, msi_en = 0;
   logic [4:0] irq_vec = '0;
   logic hp_busy, msg_req, msg_msix, intx;
   logic [4:0] msg_vec;
   logic [15:0] slot_ctl, slot_sts;

   int total = 0, bad = 0, pulses = 0, wide = 0;
   logic msg_prev = 1'b0;
   logic [4:0] last_vec = '0;
   logic last_kind = 1'b0;

   always #2.5 clk = ~clk;

   hps_slot_ctrl u_hps_slot_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_hit_ctl(cfg_hit_ctl),
      .cfg_hit_sts(cfg_hit_sts), .cfg_wdata_ctl(cfg_wdata_ctl),
      .cfg_wdata_sts(cfg_wdata_sts), .hp_req(hp_req), .hp_insert(hp_insert),
      .hp_busy(hp_busy), .atn_press(atn_press), .msix_en(msix_en),
      .msi_en(msi_en), .irq_vec(irq_vec), .slot_ctl(slot_ctl),
      .slot_sts(slot_sts), .msg_req(msg_req), .msg_msix(msg_msix),
      .msg_vec(msg_vec), .intx(intx)
   );

   always @(negedge clk) begin
      if (rst_n && msg_req) begin
         pulses++;
         last_vec  = msg_vec;
         last_kind = msg_msix;
         if (msg_prev) wide++;
      end
      msg_prev = msg_req;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic hc, input logic hs, input logic [8:0] dc, input logic [2:0] ds);
      cfg_wr = 1; cfg_hit_ctl = hc; cfg_hit_sts = hs; cfg_wdata_ctl = dc; cfg_wdata_sts = ds;
      step(1);
      cfg_wr = 0; cfg_hit_ctl = 0; cfg_hit_sts = 0;
   endtask

   task automatic hp(input logic ins);
      hp_req = 1; hp_insert = ins; step(1); hp_req = 0;
   endtask

   task automatic atn();
      atn_press = 1; step(1); atn_press = 0;
   endtask

   task automatic t_reset();
      check("R10 ctl", slot_ctl, 16'h00F0);
      check("R10 sts", slot_sts, 16'h0000);
      check("R10 intx/msg", {intx, msg_req}, 2'b00);
   endtask

   task automatic t_intx();
      int p0 = pulses;
      wr(1, 0, 9'h0F2, 3'b000);
      check("R5 cc set", slot_sts, 16'h0004);
      hp(1);
      check("R8 presence insert", slot_sts, 16'h000E);
      step(1);
      check("R1 no ie no intx", intx, 1'b0);
      wr(1, 0, 9'h0FA, 3'b000);
      step(1);
      check("R4 intx follows", intx, 1'b1);
      wr(0, 1, 9'h000, 3'b010);
      check("R7 selective clear", slot_sts, 16'h000C);
      step(1);
      check("R4 intx drops", intx, 1'b0);
      wr(0, 1, 9'h000, 3'b100);
      check("R7 clear cc", slot_sts, 16'h0008);
      check("R4 no msg in intx mode", pulses - p0, 0);
   endtask

   task automatic t_msix();
      int p0;
      msix_en = 1; irq_vec = 5'd17;
      p0 = pulses;
      wr(1, 0, 9'h0F9, 3'b000);
      step(2);
      check("R1 cc not enabled", pulses - p0, 0);
      atn();
      check("R8 atn event", slot_sts, 16'h000D);
      step(3);
      check("R2 one pulse rise", pulses - p0, 1);
      check("R2 vector", last_vec, 5'd17);
      check("R2 msix kind", last_kind, 1'b1);
      check("R4 intx quiet msix", intx, 1'b0);
      atn();
      step(3);
      check("R3 repeat event silent", pulses - p0, 1);
      wr(1, 0, 9'h0F1, 3'b000);
      step(3);
      check("R2 pulse on fall", pulses - p0, 2);
      wr(0, 1, 9'h000, 3'b111);
      check("R7 clear all", slot_sts, 16'h0008);
      check("R2 single cycle", wide, 0);
      msix_en = 0;
   endtask

   task automatic t_msi();
      int p0 = pulses;
      msi_en = 1; irq_vec = 5'd5;
      wr(1, 0, 9'h0FC, 3'b000);
      step(3);
      check("R5 cc raises msg", pulses - p0, 1);
      check("R2 msi kind", {last_kind, last_vec}, {1'b0, 5'd5});
      wr(0, 1, 9'h000, 3'b100);
      step(3);
      check("R4 status ack silent", pulses - p0, 1);
      msi_en = 0;
      wr(1, 0, 9'h0F0, 3'b000);
      wr(1, 1, 9'h0F0, 3'b100);
      check("R5 set wins over clear", slot_sts[2], 1'b1);
      wr(0, 1, 9'h000, 3'b100);
   endtask

   task automatic t_lock();
      wr(1, 0, 9'h1F0, 3'b000);
      check("R6 lock engaged", slot_sts, 16'h001C);
      check("R6 cmd reads 0", slot_ctl, 16'h00F0);
      hp(0);
      check("R9 busy", hp_busy, 1'b1);
      check("R9 state kept", slot_sts, 16'h001C);
      step(1);
      check("R9 busy one cycle", hp_busy, 1'b0);
      wr(1, 0, 9'h1F0, 3'b000);
      check("R6 lock released", slot_sts, 16'h000C);
      hp(0);
      check("R8 removal accepted", slot_sts, 16'h0006);
      check("R9 no busy", hp_busy, 1'b0);
   endtask

   task automatic t_reset_mid();
      wr(1, 0, 9'h0FA, 3'b000);
      step(1);
      check("R4 intx before reset", intx, 1'b1);
      rst_n = 0; step(2); rst_n = 1; step(1);
      t_reset();
   endtask

   initial begin
      step(3);
      rst_n = 1;
      step(1);
      t_reset();
      t_intx();
      t_msix();
      t_msi();
      t_lock();
      t_reset_mid();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule